// File: doc/BRIEF.md
# Vector Gather/Scatter Memory Unit

This block carries out one vector memory instruction at a time for a small SIMD datapath. A single `start` pulse hands it a 5-bit opcode, a 2-bit element-size code, a base byte address and three operand vectors: per-lane store data, per-lane table indices, and per-lane accumulator words. The unit then walks the lanes in ascending order, one lane per clock. Each lane uses either a single synchronous data-memory port or a private lookup table that sits inside the unit. When the walk ends it pulses `done` and presents the destination vector on `d_vec`.

The supported operations are contiguous load and store, and gather and scatter. For gather and scatter the per-lane index comes from either the upper or the lower half of that lane's accumulator word. There are also reads and writes of the private table, which is addressed by the lane's index operand scaled by the element size. Element sizes are byte, halfword and word. The fourth size code and every opcode without a meaning run through the same lane walk with no effect on either memory and leave `d_vec` at zero.

Top module: `vgs_mem_unit`

## Requirements
- R1: Opcode 5'b00000 (load) sets lane i of `d_vec` to the element at byte address base + i*S, where S is 1, 2 or 4 bytes for size code 2'b00, 2'b01 or 2'b10. Byte and halfword elements are zero-extended to 32 bits.
- R2: Opcode 5'b00100 (store) writes the low S bytes of lane i of `a_vec` to base + i*S. `mem_be` enables exactly those bytes. Every write opcode leaves all lanes of `d_vec` at zero.
- R3: Opcodes 5'b00001 and 5'b00010 (gather) load lane i from base + k*S. For 5'b00001, k is the upper half of lane i's accumulator word (bits ACC_W-1 down to ACC_W/2). For 5'b00010, k is the lower half. k is zero-extended.
- R4: Opcodes 5'b00101 and 5'b00110 (scatter) store lane i of `a_vec` to base + k*S. The index k is selected from the accumulator halves as in R3 (upper for 5'b00101, lower for 5'b00110).
- R5: Opcode 5'b01001 writes lane i of `a_vec` into the private table at byte offset (b*S) mod TBL_BYTES, where b is lane i of `b_vec`. Opcode 5'b01000 reads the table at that offset into `d_vec`, zero-extended. The table default is 1024 bytes and holds its contents across operations. Neither opcode touches the memory port.
- R6: Size code 2'b11 makes any opcode a no-op: no memory request, no table write, and `d_vec` all zero after `done`.
- R7: Opcodes not listed in R1 to R5 issue no memory request and no table write, and leave `d_vec` all zero after `done`.
- R8: The lanes are processed in ascending order, one per clock. `done` is a one-cycle pulse on the LANES+1-th rising edge after the edge that accepts `start`. `busy` is high from the accepting edge until `done`. A `start` that arrives while `busy` is high is ignored.
- R9: Memory addresses are forced to element alignment by clearing their low log2(S) bits. Data is little-endian within the 32-bit port: byte j of the word is bits 8j+7..8j. `mem_be` has one bit set for a byte, either 4'b0011 or 4'b1100 for a halfword, and 4'b1111 for a word. Read data is taken from the matching byte lanes of `mem_rdata` one cycle after the request.
- R10: After reset, `busy`, `done` and `mem_req` are low and `d_vec` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| op | input | 5 | Memory opcode |
| wcode | input | 2 | Element size code |
| base | input | AW | Base byte address |
| a_vec | input | LANES*32 | Per-lane store/table-write data |
| b_vec | input | LANES*32 | Per-lane table index |
| acc_vec | input | LANES*ACC_W | Per-lane accumulator words (gather/scatter index halves) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| d_vec | output | LANES*32 | Destination lane data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Element-aligned byte address |
| mem_be | output | 4 | Byte enables within the 32-bit word |
| mem_wdata | output | 32 | Write data, replicated across byte lanes |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The bound checker watches, on every cycle, the properties that hold lane by lane. Memory requests appear only while busy. A write is always a request. Byte enables agree in shape and position with the aligned address. A no-op size code or unassigned opcode never reaches either memory. `done` is a single-cycle pulse that falls outside `busy`. Only the directed scenarios can show that the data is right: the lane-to-address mapping for contiguous, upper-half and lower-half indexing, zero extension, table wrap at the top of its range, the exact done latency, and that a `start` arriving mid-walk leaves the running result and memory untouched.

// File: rtl/vgs_pkg.sv
`timescale 1ns/1ps
package vgs_pkg;

   localparam int unsigned VGS_DW = 32;

   typedef enum logic [4:0] {
      OPC_LOAD       = 5'b00000,
      OPC_GATHER_UP  = 5'b00001,
      OPC_GATHER_LOW = 5'b00010,
      OPC_STORE      = 5'b00100,
      OPC_SCATTER_UP = 5'b00101,
      OPC_SCATTER_LOW= 5'b00110,
      OPC_TBL_READ   = 5'b01000,
      OPC_TBL_WRITE  = 5'b01001
   } vgs_opc_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RUN,
      ST_DRAIN
   } vgs_state_e;

   // decoded control for one operation
   typedef struct packed {
      logic rd;    // lane produces destination data
      logic wr;    // lane writes somewhere
      logic tbl;   // target is the private table
      logic idx;   // address index comes from accumulator
      logic up;    // use upper accumulator half
   } vgs_ctl_t;

   function automatic vgs_ctl_t vgs_decode(input logic [4:0] opc, input logic [1:0] wc);
      vgs_ctl_t c;
      c = '0;
      if (wc != 2'b11) begin
         case (opc)
            OPC_LOAD:        c.rd = 1'b1;
            OPC_GATHER_UP:   begin c.rd = 1'b1; c.idx = 1'b1; c.up = 1'b1; end
            OPC_GATHER_LOW:  begin c.rd = 1'b1; c.idx = 1'b1; end
            OPC_STORE:       c.wr = 1'b1;
            OPC_SCATTER_UP:  begin c.wr = 1'b1; c.idx = 1'b1; c.up = 1'b1; end
            OPC_SCATTER_LOW: begin c.wr = 1'b1; c.idx = 1'b1; end
            OPC_TBL_READ:    begin c.rd = 1'b1; c.tbl = 1'b1; end
            OPC_TBL_WRITE:   begin c.wr = 1'b1; c.tbl = 1'b1; end
            default:         c = '0;
         endcase
      end
      return c;
   endfunction

   // byte enables for an element at byte offset off within the word
   function automatic logic [3:0] vgs_strobe(input logic [1:0] wc, input logic [1:0] off);
      case (wc)
         2'b00:   return 4'b0001 << off;
         2'b01:   return off[1] ? 4'b1100 : 4'b0011;
         default: return 4'b1111;
      endcase
   endfunction

   // replicate element so every enabled byte lane carries it
   function automatic logic [VGS_DW-1:0] vgs_spread(input logic [1:0] wc, input logic [VGS_DW-1:0] val);
      case (wc)
         2'b00:   return {4{val[7:0]}};
         2'b01:   return {2{val[15:0]}};
         default: return val;
      endcase
   endfunction

   // extract and zero-extend an element from a word
   function automatic logic [VGS_DW-1:0] vgs_pick(input logic [1:0] wc, input logic [1:0] off,
                                                   input logic [VGS_DW-1:0] word);
      case (wc)
         2'b00:   return VGS_DW'(word[{off, 3'b000} +: 8]);
         2'b01:   return VGS_DW'(word[{off[1], 4'b0000} +: 16]);
         default: return word;
      endcase
   endfunction

endpackage

// File: rtl/vgs_addr_gen.sv
`timescale 1ns/1ps
module vgs_addr_gen
   import vgs_pkg::*;
#(
   parameter int unsigned AW     = 32,
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned LANE_W = 4,
   parameter int unsigned TBL_AW = 10
) (
   input  vgs_ctl_t              ctl,
   input  logic [1:0]            wc,
   input  logic [AW-1:0]         base,
   input  logic [LANE_W-1:0]     lane,
   input  logic [ACC_W-1:0]      acc,
   input  logic [VGS_DW-1:0]     bval,
   output logic [AW-1:0]         mem_addr,
   output logic [TBL_AW-1:0]     tbl_addr
);

   localparam int unsigned HALF = ACC_W / 2;

   logic [AW-1:0]     idx;
   logic [AW-1:0]     raw;
   logic [AW-1:0]     amask;
   logic [TBL_AW-1:0] traw;
   logic [TBL_AW-1:0] tmask;

   always_comb begin
      if (!ctl.idx)
         idx = AW'(lane);
      else if (ctl.up)
         idx = AW'(acc[ACC_W-1:HALF]);
      else
         idx = AW'(acc[HALF-1:0]);
   end

   assign raw      = base + (idx << wc);
   assign amask    = ~((AW'(1) << wc) - AW'(1));
   assign mem_addr = raw & amask;

   // table offset wraps at the table size, then is aligned
   assign traw     = TBL_AW'(bval << wc);
   assign tmask    = ~((TBL_AW'(1) << wc) - TBL_AW'(1));
   assign tbl_addr = traw & tmask;

endmodule

// File: rtl/vgs_table.sv
`timescale 1ns/1ps
module vgs_table #(
   parameter int unsigned BYTES = 1024
) (
   input  logic                           clk,
   input  logic                           re,
   input  logic                           we,
   input  logic [3:0]                     be,
   input  logic [$clog2(BYTES/4)-1:0]     waddr,
   input  logic [31:0]                    wdata,
   output logic [31:0]                    rdata
);

   localparam int unsigned WORDS = BYTES / 4;

   for (genvar k = 0; k < 4; k++) begin : g_bank
      logic [7:0] bank [WORDS];
      logic [7:0] q;

      always_ff @(posedge clk) begin
         if (we && be[k])
            bank[waddr] <= wdata[8*k +: 8];
         if (re)
            q <= bank[waddr];
      end

      assign rdata[8*k +: 8] = q;
   end

endmodule

// File: rtl/vgs_mem_unit.sv
`timescale 1ns/1ps
module vgs_mem_unit
   import vgs_pkg::*;
#(
   parameter int unsigned LANES     = 16,
   parameter int unsigned AW        = 32,
   parameter int unsigned ACC_W     = 32,
   parameter int unsigned TBL_BYTES = 1024
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [4:0]               op,
   input  logic [1:0]               wcode,
   input  logic [AW-1:0]            base,
   input  logic [LANES*32-1:0]      a_vec,
   input  logic [LANES*32-1:0]      b_vec,
   input  logic [LANES*ACC_W-1:0]   acc_vec,
   output logic                     busy,
   output logic                     done,
   output logic [LANES*32-1:0]      d_vec,
   output logic                     mem_req,
   output logic                     mem_we,
   output logic [AW-1:0]            mem_addr,
   output logic [3:0]               mem_be,
   output logic [31:0]              mem_wdata,
   input  logic [31:0]              mem_rdata
);

   localparam int unsigned LANE_W = $clog2(LANES);
   localparam int unsigned TBL_AW = $clog2(TBL_BYTES);
   localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

   // elaboration-time parameter checks
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("vgs_mem_unit: LANES must be a power of two of at least 2");
   end
   if (ACC_W < 2 || (ACC_W % 2) != 0 || ACC_W / 2 > AW) begin : g_bad_acc
      $error("vgs_mem_unit: ACC_W must be even and its half no wider than AW");
   end
   if (TBL_BYTES < 8 || (TBL_BYTES & (TBL_BYTES - 1)) != 0 || TBL_AW > 32) begin : g_bad_tbl
      $error("vgs_mem_unit: TBL_BYTES must be a power of two between 8 and 2^32");
   end
   if (AW < 2) begin : g_bad_aw
      $error("vgs_mem_unit: AW too small");
   end

   vgs_state_e          state;
   logic [LANE_W-1:0]   lane_q;
   vgs_ctl_t            ctl_q;
   logic [1:0]          wc_q;
   logic [AW-1:0]       base_q;
   logic                done_q;

   logic [31:0]         a_q   [LANES];
   logic [31:0]         b_q   [LANES];
   logic [ACC_W-1:0]    acc_q [LANES];
   logic [31:0]         d_q   [LANES];

   // response slot: the lane issued last cycle
   logic                cap_v;
   logic [LANE_W-1:0]   cap_lane;
   logic [1:0]          cap_off;
   logic                cap_tbl;

   logic                run;
   logic                accept;
   logic [AW-1:0]       cur_addr;
   logic [TBL_AW-1:0]   tbl_addr;
   logic                tbl_re;
   logic                tbl_we;
   logic [31:0]         tbl_rdata;
   logic [31:0]         rsp_word;

   assign run    = (state == ST_RUN);
   assign accept = (state == ST_IDLE) && start;

   // operand capture at acceptance so inputs may change during the walk
   always_ff @(posedge clk) begin
      if (accept) begin
         for (int i = 0; i < LANES; i++) begin
            a_q[i]   <= a_vec[i*32 +: 32];
            b_q[i]   <= b_vec[i*32 +: 32];
            acc_q[i] <= acc_vec[i*ACC_W +: ACC_W];
         end
      end
   end

   vgs_addr_gen #(
      .AW     (AW),
      .ACC_W  (ACC_W),
      .LANE_W (LANE_W),
      .TBL_AW (TBL_AW)
   ) u_addr (
      .ctl      (ctl_q),
      .wc       (wc_q),
      .base     (base_q),
      .lane     (lane_q),
      .acc      (acc_q[lane_q]),
      .bval     (b_q[lane_q]),
      .mem_addr (cur_addr),
      .tbl_addr (tbl_addr)
   );

   assign tbl_re = run && ctl_q.tbl && ctl_q.rd;
   assign tbl_we = run && ctl_q.tbl && ctl_q.wr;

   vgs_table #(
      .BYTES (TBL_BYTES)
   ) u_tbl (
      .clk   (clk),
      .re    (tbl_re),
      .we    (tbl_we),
      .be    (vgs_strobe(wc_q, tbl_addr[1:0])),
      .waddr (tbl_addr[TBL_AW-1:2]),
      .wdata (vgs_spread(wc_q, a_q[lane_q])),
      .rdata (tbl_rdata)
   );

   // memory port
   assign mem_req   = run && (ctl_q.rd || ctl_q.wr) && !ctl_q.tbl;
   assign mem_we    = run && ctl_q.wr && !ctl_q.tbl;
   assign mem_addr  = cur_addr;
   assign mem_be    = mem_req ? vgs_strobe(wc_q, cur_addr[1:0]) : 4'b0000;
   assign mem_wdata = vgs_spread(wc_q, a_q[lane_q]);

   assign rsp_word  = cap_tbl ? tbl_rdata : mem_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         lane_q   <= '0;
         ctl_q    <= '0;
         wc_q     <= 2'b00;
         base_q   <= '0;
         done_q   <= 1'b0;
         cap_v    <= 1'b0;
         cap_lane <= '0;
         cap_off  <= 2'b00;
         cap_tbl  <= 1'b0;
         for (int i = 0; i < LANES; i++)
            d_q[i] <= '0;
      end else begin
         done_q <= 1'b0;
         cap_v  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state  <= ST_RUN;
                  lane_q <= '0;
                  ctl_q  <= vgs_decode(op, wcode);
                  wc_q   <= wcode;
                  base_q <= base;
                  for (int i = 0; i < LANES; i++)
                     d_q[i] <= '0;
               end
            end
            ST_RUN: begin
               cap_v    <= ctl_q.rd;
               cap_lane <= lane_q;
               cap_off  <= ctl_q.tbl ? tbl_addr[1:0] : cur_addr[1:0];
               cap_tbl  <= ctl_q.tbl;
               if (lane_q == LAST_LANE)
                  state <= ST_DRAIN;
               else
                  lane_q <= lane_q + LANE_W'(1);
            end
            ST_DRAIN: begin
               state  <= ST_IDLE;
               done_q <= 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
         if (cap_v)
            d_q[cap_lane] <= vgs_pick(wc_q, cap_off, rsp_word);
      end
   end

   assign busy = (state != ST_IDLE);
   assign done = done_q;

   for (genvar g = 0; g < LANES; g++) begin : g_dout
      assign d_vec[g*32 +: 32] = d_q[g];
   end

endmodule

// File: rtl/vgs_mem_unit_chk.sv
`timescale 1ns/1ps
module vgs_mem_unit_chk #(
   parameter int unsigned AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          mem_req,
   input logic          mem_we,
   input logic [3:0]    mem_be,
   input logic [AW-1:0] mem_addr,
   input logic          tbl_we,
   input logic [1:0]    wc_q,
   input logic          ctl_act
);

   // R8
   req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   // R2
   write_is_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R9
   strobe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

   // R9
   word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_be == 4'b1111) |-> (mem_addr[1:0] == 2'b00));

   // R9
   half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $countones(mem_be) == 2) |-> (mem_addr[0] == 1'b0 && mem_be == (mem_addr[1] ? 4'b1100 : 4'b0011)));

   // R9
   byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $countones(mem_be) == 1) |-> (mem_be == (4'b0001 << mem_addr[1:0])));

   // R6
   size_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wc_q == 2'b11) |-> (!mem_req && !tbl_we));

   // R7
   inert_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ctl_act) |-> (!mem_req && !tbl_we));

   // R8
   walk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy);

endmodule

bind vgs_mem_unit vgs_mem_unit_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_be   (mem_be),
   .mem_addr (mem_addr),
   .tbl_we   (tbl_we),
   .wc_q     (wc_q),
   .ctl_act  (ctl_q.rd | ctl_q.wr)
);

// File: tb/vgs_mem_unit_tb_top.sv
`timescale 1ns/1ps
module vgs_mem_unit_tb_top;

   localparam int LANES = 16;
   localparam int AW    = 32;
   localparam int ACC_W = 32;
   localparam int TBLB  = 1024;

   logic                   clk = 1'b0;
   logic                   rst_n;
   logic                   start;
   logic [4:0]             op;
   logic [1:0]             wcode;
   logic [AW-1:0]          base;
   logic [LANES*32-1:0]    a_vec;
   logic [LANES*32-1:0]    b_vec;
   logic [LANES*ACC_W-1:0] acc_vec;
   logic                   busy;
   logic                   done;
   logic [LANES*32-1:0]    d_vec;
   logic                   mem_req;
   logic                   mem_we;
   logic [AW-1:0]          mem_addr;
   logic [3:0]             mem_be;
   logic [31:0]            mem_wdata;
   logic [31:0]            mem_rdata;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   vgs_mem_unit #(
      .LANES(LANES), .AW(AW), .ACC_W(ACC_W), .TBL_BYTES(TBLB)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wcode(wcode), .base(base),
      .a_vec(a_vec), .b_vec(b_vec), .acc_vec(acc_vec), .busy(busy), .done(done),
      .d_vec(d_vec), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // ---------------- memory model ----------------
   logic [7:0]    mem_b   [4096];
   logic [7:0]    lut_ref [TBLB];
   logic [AW-1:0] req_log [64];
   int unsigned   req_cnt = 0;

   function automatic logic [7:0] pat(input int unsigned a);
      return 8'((a * 13 + 5) & 255);
   endfunction

   function automatic logic [31:0] pexp(input int unsigned a, input int nb);
      logic [31:0] v = '0;
      for (int k = 0; k < nb; k++) v |= 32'(pat(a + k)) << (8 * k);
      return v;
   endfunction

   function automatic logic [31:0] memrd(input int unsigned a, input int nb);
      logic [31:0] v = '0;
      for (int k = 0; k < nb; k++) v |= 32'(mem_b[(a + k) % 4096]) << (8 * k);
      return v;
   endfunction

   function automatic logic [31:0] lutrd(input int unsigned a, input int nb);
      logic [31:0] v = '0;
      for (int k = 0; k < nb; k++) v |= 32'(lut_ref[(a + k) % TBLB]) << (8 * k);
      return v;
   endfunction

   initial begin
      for (int k = 0; k < 4096; k++) mem_b[k] = pat(k);
      for (int k = 0; k < TBLB; k++) lut_ref[k] = 8'h00;
   end

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) begin
            for (int k = 0; k < 4; k++)
               if (mem_be[k]) mem_b[{mem_addr[11:2], 2'(k)}] = mem_wdata[8*k +: 8];
         end else begin
            mem_rdata <= {mem_b[{mem_addr[11:2], 2'd3}], mem_b[{mem_addr[11:2], 2'd2}],
                          mem_b[{mem_addr[11:2], 2'd1}], mem_b[{mem_addr[11:2], 2'd0}]};
         end
         req_log[req_cnt % 64] = mem_addr;
         req_cnt = req_cnt + 1;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   function automatic logic [31:0] dlane(input int i);
      return d_vec[i*32 +: 32];
   endfunction

   task automatic set_lane(input int i, input logic [31:0] av, input logic [31:0] bv,
                           input logic [31:0] accv);
      a_vec[i*32 +: 32]     = av;
      b_vec[i*32 +: 32]     = bv;
      acc_vec[i*ACC_W +: ACC_W] = accv;
   endtask

   // start an operation, wait for done, check the latency (R8)
   task automatic run_op(input logic [4:0] o, input logic [1:0] w, input logic [AW-1:0] b,
                         input string tag);
      int cnt;
      @(negedge clk);
      op = o; wcode = w; base = b; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cnt = 0;
      while (done !== 1'b1 && cnt < 100) begin
         @(posedge clk);
         @(negedge clk);
         cnt++;
      end
      chk($sformatf("R8 done latency %s", tag), 32'(cnt), 32'(LANES + 1));
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      rst_n = 1'b0; start = 1'b0; op = '0; wcode = '0; base = '0;
      a_vec = '0; b_vec = '0; acc_vec = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 busy after reset", 32'(busy), 32'd0);
      chk("R10 done after reset", 32'(done), 32'd0);
      chk("R10 mem_req after reset", 32'(mem_req), 32'd0);
      for (int i = 0; i < LANES; i++) chk($sformatf("R10 d lane %0d", i), dlane(i), 32'd0);
   endtask

   task automatic t_load;
      int unsigned c0;
      c0 = req_cnt;
      run_op(5'b00000, 2'b10, 32'h200, "load32");
      chk("R1 load32 request count", req_cnt - c0, 32'd16);
      for (int i = 0; i < LANES; i++) begin
         chk($sformatf("R1 load32 lane %0d", i), dlane(i), pexp(32'h200 + 4*i, 4));
         chk($sformatf("R8 ascending addr lane %0d", i), req_log[(c0 + i) % 64], 32'h200 + 4*i);
      end
      run_op(5'b00000, 2'b00, 32'h203, "load8");
      for (int i = 0; i < LANES; i++)
         chk($sformatf("R1 load8 zero-ext lane %0d", i), dlane(i), pexp(32'h203 + i, 1));
      c0 = req_cnt;
      run_op(5'b00000, 2'b01, 32'h101, "load16 unaligned");
      for (int i = 0; i < LANES; i++) begin
         chk($sformatf("R9 load16 aligned data lane %0d", i), dlane(i), pexp(32'h100 + 2*i, 2));
         chk($sformatf("R9 load16 aligned addr lane %0d", i), req_log[(c0 + i) % 64], 32'h100 + 2*i);
      end
   endtask

   task automatic t_gather;
      for (int i = 0; i < LANES; i++)
         set_lane(i, 32'h0, 32'h0, {16'(15 - i), 16'(3 * i)});
      run_op(5'b00001, 2'b10, 32'h300, "gather upper");
      for (int i = 0; i < LANES; i++)
         chk($sformatf("R3 gather upper lane %0d", i), dlane(i), pexp(32'h300 + 4*(15 - i), 4));
      run_op(5'b00010, 2'b01, 32'h300, "gather lower");
      for (int i = 0; i < LANES; i++)
         chk($sformatf("R3 gather lower lane %0d", i), dlane(i), pexp(32'h300 + 2*(3 * i), 2));
   endtask

   task automatic t_store;
      for (int i = 0; i < LANES; i++)
         set_lane(i, 32'hC0DE0000 | 32'(i * 32'h111), 32'h0, 32'h0);
      run_op(5'b00100, 2'b10, 32'h800, "store32");
      for (int i = 0; i < LANES; i++) begin
         chk($sformatf("R2 store32 mem lane %0d", i), memrd(32'h800 + 4*i, 4), a_vec[i*32 +: 32]);
         chk($sformatf("R2 store32 d zero lane %0d", i), dlane(i), 32'd0);
      end
      run_op(5'b00100, 2'b01, 32'h843, "store16");
      for (int i = 0; i < LANES; i++)
         chk($sformatf("R2 store16 mem lane %0d", i), memrd(32'h842 + 2*i, 2), {16'h0, a_vec[i*32 +: 16]});
      chk("R9 store16 byte below untouched", memrd(32'h841, 1), pexp(32'h841, 1));
      chk("R9 store16 byte above untouched", memrd(32'h862, 1), pexp(32'h862, 1));
   endtask

   task automatic t_scatter;
      for (int i = 0; i < LANES; i++)
         set_lane(i, 32'h5A000000 | 32'(i * 32'h01010107), 32'h0, {16'(2 * i), 16'(15 - i)});
      run_op(5'b00101, 2'b00, 32'hA00, "scatter upper8");
      for (int i = 0; i < LANES; i++) begin
         chk($sformatf("R4 scatter upper8 lane %0d", i), memrd(32'hA00 + 2*i, 1), {24'h0, a_vec[i*32 +: 8]});
         chk($sformatf("R4 scatter8 neighbour lane %0d", i), memrd(32'hA01 + 2*i, 1), pexp(32'hA01 + 2*i, 1));
      end
      run_op(5'b00110, 2'b10, 32'hB00, "scatter lower32");
      for (int i = 0; i < LANES; i++)
         chk($sformatf("R4 scatter lower32 lane %0d", i), memrd(32'hB00 + 4*(15 - i), 4), a_vec[i*32 +: 32]);
   endtask

   task automatic t_table;
      int unsigned c0;
      c0 = req_cnt;
      for (int i = 0; i < LANES; i++) begin
         set_lane(i, 32'h7E000000 + 32'(i * 32'h00031337), 32'(250 + i), 32'h0);
         for (int k = 0; k < 4; k++)
            lut_ref[(1000 + 4*i + k) % TBLB] = a_vec[i*32 + 8*k +: 8];
      end
      run_op(5'b01001, 2'b10, 32'h0, "table write32 wrap");
      run_op(5'b01000, 2'b10, 32'h0, "table read32 wrap");
      for (int i = 0; i < LANES; i++)
         chk($sformatf("R5 table read32 lane %0d", i), dlane(i), lutrd((1000 + 4*i) % TBLB, 4));
      chk("R5 table ops use no memory port", req_cnt - c0, 32'd0);
      for (int i = 0; i < LANES; i++) set_lane(i, 32'h0, 32'(1000 + i), 32'h0);
      run_op(5'b01000, 2'b00, 32'h0, "table read8");
      for (int i = 0; i < LANES; i++)
         chk($sformatf("R5 table read8 lane %0d", i), dlane(i), lutrd(1000 + i, 1));
      for (int i = 0; i < LANES; i++) set_lane(i, 32'h0, 32'(500 + i), 32'h0);
      run_op(5'b01000, 2'b01, 32'h0, "table read16 wrap");
      for (int i = 0; i < LANES; i++)
         chk($sformatf("R5 table read16 lane %0d", i), dlane(i), lutrd((1000 + 2*i) % TBLB, 2));
   endtask

   task automatic t_noop_size;
      int unsigned c0;
      c0 = req_cnt;
      run_op(5'b00000, 2'b11, 32'h200, "size11 load");
      chk("R6 size11 load no request", req_cnt - c0, 32'd0);
      for (int i = 0; i < LANES; i++) chk($sformatf("R6 size11 d lane %0d", i), dlane(i), 32'd0);
      for (int i = 0; i < LANES; i++) set_lane(i, 32'hDEADBEEF, 32'(250 + i), 32'h0);
      run_op(5'b00100, 2'b11, 32'h900, "size11 store");
      chk("R6 size11 store no request", req_cnt - c0, 32'd0);
      chk("R6 size11 store mem untouched", memrd(32'h900, 4), pexp(32'h900, 4));
      run_op(5'b01001, 2'b11, 32'h0, "size11 table write");
      run_op(5'b01000, 2'b10, 32'h0, "table readback");
      for (int i = 0; i < LANES; i++)
         chk($sformatf("R6 table unchanged lane %0d", i), dlane(i), lutrd((1000 + 4*i) % TBLB, 4));
   endtask

   task automatic t_unassigned;
      int unsigned c0;
      run_op(5'b00000, 2'b10, 32'h200, "preload");
      c0 = req_cnt;
      run_op(5'b11000, 2'b10, 32'h200, "opcode 11000");
      for (int i = 0; i < LANES; i++) chk($sformatf("R7 opcode 11000 d lane %0d", i), dlane(i), 32'd0);
      for (int i = 0; i < LANES; i++) set_lane(i, 32'h13572468, 32'(250 + i), 32'(i));
      run_op(5'b00111, 2'b10, 32'h900, "opcode 00111");
      run_op(5'b01010, 2'b10, 32'h0, "opcode 01010");
      chk("R7 unassigned no request", req_cnt - c0, 32'd0);
      chk("R7 unassigned mem untouched", memrd(32'h900, 4), pexp(32'h900, 4));
      run_op(5'b01000, 2'b10, 32'h0, "table readback 2");
      for (int i = 0; i < LANES; i++)
         chk($sformatf("R7 table unchanged lane %0d", i), dlane(i), lutrd((1000 + 4*i) % TBLB, 4));
   endtask

   task automatic t_busy_ignore;
      int unsigned c0;
      int cnt;
      for (int i = 0; i < LANES; i++) set_lane(i, 32'hFFFFFFFF, 32'h0, 32'h0);
      c0 = req_cnt;
      @(negedge clk);
      op = 5'b00000; wcode = 2'b10; base = 32'h200; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      op = 5'b00100; base = 32'h200; start = 1'b1;    // arrives mid-walk
      @(negedge clk);
      start = 1'b0;
      cnt = 0;
      while (done !== 1'b1 && cnt < 100) begin
         @(negedge clk);
         cnt++;
      end
      chk("R8 busy-start request count", req_cnt - c0, 32'd16);
      for (int i = 0; i < LANES; i++)
         chk($sformatf("R8 busy-start load lane %0d", i), dlane(i), pexp(32'h200 + 4*i, 4));
      chk("R8 busy-start mem untouched", memrd(32'h200, 4), pexp(32'h200, 4));
      @(negedge clk);
      chk("R8 done one cycle", 32'(done), 32'd0);
   endtask

   // ---------------- sequence ----------------
   initial begin
      t_reset();
      t_load();
      t_gather();
      t_store();
      t_scatter();
      t_table();
      t_noop_size();
      t_unassigned();
      t_busy_ignore();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R8 watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule